// File: doc/BRIEF.md
# Staged Two-Byte Display Word Register

This block assembles a double-width value from a narrow data bus and presents it on an output that is always driven, typically to feed a numeric display decoder. The word is loaded in two bus cycles. First a stage strobe parks the low byte in a hidden holding register. Then a commit strobe moves the byte on the bus into the upper half of the word and the held byte into the lower half, both on the same clock edge.

Because the visible word changes only on a commit edge, and both halves change together there, a viewer never sees a mix of the old and new values. For example, 0x0000 never passes through 0x00FF on its way to 0xFFFF. The reset input is asynchronous and active low. It is released synchronously inside the block.

Top module: `split_load_word`

## Requirements
- R1: While reset is asserted, and after it is released until the first commit, `word_o` reads 0x0000. Reset also clears the holding byte to 0x00.
- R2: A cycle with `stage_i` high and `commit_i` low captures `bus_i` into the holding byte and leaves `word_o` unchanged at that edge.
- R3: A cycle with `commit_i` high sets `word_o[15:8]` to that cycle's `bus_i` and `word_o[7:0]` to the holding byte as it stood before the edge. Both halves update on the same edge.
- R4: A cycle with `commit_i` low leaves `word_o` unchanged.
- R5: When `stage_i` and `commit_i` are both high in one cycle, the commit uses the holding byte from before that edge, and the holding byte also takes `bus_i`. The next commit then places that bus value in the low half.
- R6: A commit that has no stage since the previous commit reuses the holding byte that is still held. After reset, with no stage at all, that byte is 0x00.
- R7: `word_o` moves from one committed value directly to the next. A change from 0x0000 to 0xFFFF shows no intermediate value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously |
| bus_i | input | 8 | Data bus byte |
| stage_i | input | 1 | Capture the bus byte into the holding register |
| commit_i | input | 1 | Load the word: bus byte to the upper half, held byte to the lower half |
| word_o | output | 16 | Displayed word, always driven |

## Verification
The assertions check on every cycle that the word holds whenever no commit occurs. They also check that each commit lands the previous bus byte in the upper half and the previous holding byte in the lower half, and that each stage captures the bus. Only the bench scenarios can show the sequences that span several commands: the 0x0000 to 0xFFFF transition seen cycle by cycle, a commit with no stage after reset, and a combined stage-and-commit cycle whose effect appears only at the following commit.

// File: rtl/split_load_word_pkg.sv
package split_load_word_pkg;
  localparam int unsigned BYTE_W_DEF   = 8;
  localparam int unsigned SYNC_DEPTH   = 2;
endpackage

// File: rtl/slw_rst_sync.sv
module slw_rst_sync #(
  parameter int unsigned DEPTH = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);
  logic [DEPTH-1:0] chain_q, chain_d;

  always_comb begin
    chain_d = {chain_q[DEPTH-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign rst_sync_no = chain_q[DEPTH-1];
endmodule

// File: rtl/slw_hold_byte.sv
module slw_hold_byte #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] hold_q, hold_d;

  always_comb begin
    hold_d = hold_q;
    if (en_i) hold_d = d_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) hold_q <= '0;
    else         hold_q <= hold_d;
  end

  assign q_o = hold_q;
endmodule

// File: rtl/slw_word_reg.sv
module slw_word_reg #(
  parameter int unsigned W = 8
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           load_i,
  input  logic [W-1:0]   hi_i,
  input  logic [W-1:0]   lo_i,
  output logic [2*W-1:0] word_o
);
  logic [2*W-1:0] word_q, word_d;

  always_comb begin
    word_d = word_q;
    if (load_i) word_d = {hi_i, lo_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) word_q <= '0;
    else         word_q <= word_d;
  end

  assign word_o = word_q;
endmodule

// File: rtl/split_load_word.sv
module split_load_word
  import split_load_word_pkg::*;
#(
  parameter int unsigned BYTE_W = BYTE_W_DEF,
  localparam int unsigned WORD_W = 2 * BYTE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [BYTE_W-1:0] bus_i,
  input  logic              stage_i,
  input  logic              commit_i,
  output logic [WORD_W-1:0] word_o
);
  logic              rst_int_n;
  logic [BYTE_W-1:0] held_byte;

  slw_rst_sync #(.DEPTH(SYNC_DEPTH)) u_rst (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rst_sync_no (rst_int_n)
  );

  slw_hold_byte #(.W(BYTE_W)) u_hold (
    .clk_i  (clk_i),
    .rst_ni (rst_int_n),
    .en_i   (stage_i),
    .d_i    (bus_i),
    .q_o    (held_byte)
  );

  slw_word_reg #(.W(BYTE_W)) u_word (
    .clk_i  (clk_i),
    .rst_ni (rst_int_n),
    .load_i (commit_i),
    .hi_i   (bus_i),
    .lo_i   (held_byte),
    .word_o (word_o)
  );
endmodule

// File: rtl/split_load_word_chk.sv
module split_load_word_chk #(
  parameter int unsigned BYTE_W = 8
) (
  input logic                clk_i,
  input logic                rst_int_n,
  input logic [BYTE_W-1:0]   bus_i,
  input logic                stage_i,
  input logic                commit_i,
  input logic [BYTE_W-1:0]   held_byte,
  input logic [2*BYTE_W-1:0] word_o
);
  // R1
  always @(posedge clk_i) begin
    if (!rst_int_n) reset_word_zero_chk: assert (word_o == '0);
  end

  // R4
  word_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_int_n)
    !commit_i |=> $stable(word_o));

  // R2
  stage_capture_chk: assert property (@(posedge clk_i) disable iff (!rst_int_n)
    stage_i |=> held_byte == $past(bus_i));

  // R3
  commit_upper_chk: assert property (@(posedge clk_i) disable iff (!rst_int_n)
    commit_i |=> word_o[2*BYTE_W-1:BYTE_W] == $past(bus_i));

  // R3
  commit_lower_chk: assert property (@(posedge clk_i) disable iff (!rst_int_n)
    commit_i |=> word_o[BYTE_W-1:0] == $past(held_byte));

  // R6
  no_stage_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_int_n)
    !stage_i |=> $stable(held_byte));
endmodule

bind split_load_word split_load_word_chk #(.BYTE_W(BYTE_W)) u_chk (
  .clk_i     (clk_i),
  .rst_int_n (rst_int_n),
  .bus_i     (bus_i),
  .stage_i   (stage_i),
  .commit_i  (commit_i),
  .held_byte (held_byte),
  .word_o    (word_o)
);

// File: tb/split_load_word_tb_top.sv
module split_load_word_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  bus;
  logic        stage, commit;
  logic [15:0] word;

  int unsigned n_run = 0, n_fail = 0;
  logic [7:0]  m_hold;
  logic [15:0] m_word;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  split_load_word dut_i (
    .clk_i(clk), .rst_ni(rst_n), .bus_i(bus),
    .stage_i(stage), .commit_i(commit), .word_o(word)
  );

  function automatic logic [15:0] nxt_word(logic c, logic [7:0] b, logic [7:0] h, logic [15:0] w);
    return c ? {b, h} : w;
  endfunction

  function automatic logic [7:0] nxt_hold(logic s, logic [7:0] b, logic [7:0] h);
    return s ? b : h;
  endfunction

  task automatic check(string req, logic [15:0] exp);
    n_run++;
    if (word !== exp) begin
      n_fail++;
      $display("FAIL %s: word=%h expected=%h", req, word, exp);
    end
  endtask

  // Called at a negedge: drive, clock, update model, sample at next negedge.
  task automatic cyc(logic s, logic c, logic [7:0] b);
    stage = s; commit = c; bus = b;
    @(posedge clk);
    m_word = nxt_word(c, b, m_hold, m_word);
    m_hold = nxt_hold(s, b, m_hold);
    @(negedge clk);
  endtask

  initial begin
    #400000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run did not finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    rst_n = 1'b0; stage = 0; commit = 0; bus = 8'hA5;
    m_hold = 8'h00; m_word = 16'h0000;
    repeat (3) @(negedge clk);
    check("R1 in reset", 16'h0000);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 after release", 16'h0000);

    // R6: commit with no stage after reset uses cleared holding byte
    cyc(0, 1, 8'h3C);
    check("R6 commit without stage after reset", 16'h3C00);

    // R7: 0x0000 -> 0xFFFF directly
    cyc(0, 1, 8'h00);
    check("R3 load zero", 16'h0000);
    cyc(1, 0, 8'hFF);
    check("R2/R7 stage leaves word at 0000", 16'h0000);
    cyc(0, 0, 8'h12);
    check("R4/R7 idle keeps 0000", 16'h0000);
    cyc(0, 1, 8'hFF);
    check("R3/R7 commit gives FFFF", 16'hFFFF);

    // R6: repeated commit reuses held byte
    cyc(0, 1, 8'h81);
    check("R6 commit reuses held FF", 16'h81FF);

    // R5: simultaneous stage and commit
    cyc(1, 0, 8'h11);
    check("R2 stage 11", 16'h81FF);
    cyc(1, 1, 8'h22);
    check("R5 combined uses old held 11", 16'h2211);
    cyc(0, 1, 8'h33);
    check("R5 next commit uses 22", 16'h3322);

    // R4: idle with changing bus
    for (int i = 0; i < 4; i++) begin
      cyc(0, 0, 8'(i * 37));
      check("R4 idle hold", 16'h3322);
    end

    // Random mix
    for (int i = 0; i < 400; i++) begin
      logic s, c;
      s = ($urandom % 3) == 0;
      c = ($urandom % 4) == 0;
      cyc(s, c, 8'($urandom));
      check("R3/R4/R7 random", m_word);
    end

    // R1 again: reset mid-run clears word and holding byte
    rst_n = 1'b0;
    @(negedge clk);
    m_word = 16'h0000; m_hold = 8'h00;
    check("R1 async reset", 16'h0000);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    cyc(0, 1, 8'h5A);
    check("R1/R6 holding byte cleared by reset", 16'h5A00);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule